// File: doc/BRIEF.md
# SPI Register-File Slave Port

This block lets an SPI master read and write a 64-byte space of registers and RAM. The master selects the block by pulling chip-enable low. The first byte it sends is a command/address byte. Every byte after that is data. Each data byte is followed by an automatic step of the location pointer. The block oversamples the serial lines with its own system clock. It turns completed bytes into single-cycle strobes on a byte-wide read/write bus, and that bus reaches the register file that sits beside it.

The block works with a master that idles its serial clock low and with one that idles it high, and it needs no configuration for either. It samples on every rising serial-clock edge and updates its output on every falling edge. A power-fail input aborts the current access and silences the port until chip-enable is released.

The register-file bus has no back-pressure. The serial master cannot be stalled, so the register file must take a write strobe and answer a read in the same cycle the strobe is high. Read data is taken from `rf_rdata` in the cycle that `rf_rd_en` is high.

Top module: `spi_regfile_slave`

## Requirements
- R1: After reset, `rf_wr_en`, `rf_rd_en`, `spi_miso` and `spi_miso_oe` are all 0.
- R2: Serial input is taken MSB first on rising `spi_sclk` edges. Each completed data byte of a write transfer produces exactly one `rf_wr_en` pulse, and `rf_wdata` carries that byte.
- R3: The first byte of a transfer is the command/address byte. Bit 7 = 1 selects write and bit 7 = 0 selects read. Bit 6 has no effect. Bits 5:0 give the starting location.
- R4: Consecutive data bytes go to consecutive locations. After location 63 the next location is 0.
- R5: On a read, `spi_miso` presents the starting location's byte MSB first. Each bit becomes valid after a falling edge and is held through the rising edge that follows. Later bytes come from the following locations.
- R6: Reads and writes give identical results with the clock idling low and with the clock idling high, and nothing is configured between the two.
- R7: A byte left incomplete when chip-enable rises causes no bus access. Bus strobes occur only while the port is selected. The next selection starts again with a command/address byte.
- R8: `spi_miso_oe` is 1 exactly while the port is selected. `spi_miso` is 0 while the port is deselected and when a selection begins.
- R9: While `pwr_fail` is 1, no bus access is issued in the following cycle. Once `pwr_fail` has been seen during a selection, the rest of that selection is ignored. After deselection the port works normally again.
- R10: `rf_wr_en` and `rf_rd_en` are never high together, and each lasts one cycle. A read transfer of N data bytes issues N+1 read strobes: one after the address byte and one after each data byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spi_cs_n | input | 1 | Chip-enable, active low (asynchronous) |
| spi_sclk | input | 1 | Serial clock (asynchronous) |
| spi_mosi | input | 1 | Serial data from master (asynchronous) |
| spi_miso | output | 1 | Serial data to master |
| spi_miso_oe | output | 1 | Output enable for `spi_miso` |
| pwr_fail | input | 1 | Power-fail abort, synchronous to `clk` |
| rf_addr | output | ADDR_W | Register-file location |
| rf_wr_en | output | 1 | One-cycle write strobe |
| rf_wdata | output | DATA_W | Write data |
| rf_rd_en | output | 1 | One-cycle read strobe |
| rf_rdata | input | DATA_W | Read data, valid while `rf_rd_en` is high |

## Verification
The assertions assume that each half period of `spi_sclk` lasts at least six `clk` cycles. They also assume that chip-enable changes at least one half period away from any serial-clock edge, and that `pwr_fail` is synchronous to `clk`. Under these conditions a byte's strobe always falls inside the selection, and the prefetched byte is loaded before the falling edge that presents it. The stimulus drives every serial line on falling `clk` edges and holds each half period for eight `clk` cycles. It keeps a half period of margin around every chip-enable change. It drops `pwr_fail` only while the master is still clocking or after the selection has ended.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;
  typedef enum logic [1:0] {
    PH_ADDR = 2'd0,
    PH_DATA = 2'd1,
    PH_HALT = 2'd2
  } phase_e;
endpackage

// File: rtl/spi_rf_sync.sv
// Multi-stage synchronizer for asynchronous serial pins; exposes the
// synchronized value and the one-cycle-older copy for edge detection.
module spi_rf_sync #(
  parameter int N = 3,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] sync_out,
  output logic [N-1:0] prev_out
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [STAGES:0] chain_q;
    always_ff @(posedge clk) begin
      if (!rst_n) chain_q <= {(STAGES+1){RST_VAL[g]}};
      else        chain_q <= {chain_q[STAGES-1:0], async_in[g]};
    end
    assign sync_out[g] = chain_q[STAGES-1];
    assign prev_out[g] = chain_q[STAGES];
  end
endmodule

// File: rtl/spi_rf_rx.sv
// Input shifter: collects DATA_W bits MSB first, flags the completing bit.
module spi_rf_rx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              shift_en,
  input  logic              din,
  output logic              byte_done,
  output logic [DATA_W-1:0] byte_val
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-2:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;

  assign byte_val  = {sh_q, din};
  assign byte_done = shift_en && !clear && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (shift_en) begin
      sh_q  <= byte_val[DATA_W-2:0];
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/spi_rf_tx.sv
// Output shifter: parallel load, presents MSB on each shift request.
module spi_rf_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              shift_en,
  output logic              dout
);
  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      sh_q <= '0;
      dout <= 1'b0;
    end else if (load) begin
      sh_q <= load_val;
    end else if (shift_en) begin
      dout <= sh_q[DATA_W-1];
      sh_q <= {sh_q[DATA_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/spi_rf_ctrl.sv
// Transfer sequencer: decodes the command byte, walks the location pointer,
// issues bus strobes, and enforces the power-fail lockout.
module spi_rf_ctrl
  import spi_rf_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              pwr_fail,
  input  logic              sclk_fall,
  input  logic              byte_done,
  input  logic [DATA_W-1:0] byte_val,
  output logic [ADDR_W-1:0] rf_addr,
  output logic              rf_wr_en,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              rf_rd_en,
  output logic              rx_clear,
  output logic              tx_clear,
  output logic              tx_shift
);
  localparam int DIR_BIT = DATA_W - 1;

  phase_e            phase_q;
  logic              is_wr_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [ADDR_W-1:0] start_loc;
  logic              halted;
  logic              unused_cmd_bits;

  assign start_loc       = byte_val[ADDR_W-1:0];
  assign unused_cmd_bits = ^byte_val[DATA_W-2:ADDR_W];
  assign halted          = (phase_q == PH_HALT);
  assign rx_clear        = !sel || pwr_fail || halted;
  assign tx_clear        = !sel || pwr_fail || halted;
  assign tx_shift        = sclk_fall && (phase_q == PH_DATA) && !is_wr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q  <= PH_ADDR;
      is_wr_q  <= 1'b0;
      ptr_q    <= '0;
      rf_addr  <= '0;
      rf_wdata <= '0;
      rf_wr_en <= 1'b0;
      rf_rd_en <= 1'b0;
    end else begin
      rf_wr_en <= 1'b0;
      rf_rd_en <= 1'b0;
      if (pwr_fail) begin
        phase_q <= PH_HALT;
        ptr_q   <= '0;
      end else if (!sel) begin
        phase_q <= PH_ADDR;
        is_wr_q <= 1'b0;
      end else if (byte_done && !halted) begin
        if (phase_q == PH_ADDR) begin
          phase_q <= PH_DATA;
          is_wr_q <= byte_val[DIR_BIT];
          if (byte_val[DIR_BIT]) begin
            ptr_q <= start_loc;
          end else begin
            rf_rd_en <= 1'b1;
            rf_addr  <= start_loc;
            ptr_q    <= start_loc + 1'b1;
          end
        end else if (is_wr_q) begin
          rf_wr_en <= 1'b1;
          rf_addr  <= ptr_q;
          rf_wdata <= byte_val;
          ptr_q    <= ptr_q + 1'b1;
        end else begin
          rf_rd_en <= 1'b1;
          rf_addr  <= ptr_q;
          ptr_q    <= ptr_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_regfile_slave.sv
module spi_regfile_slave #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_cs_n,
  input  logic              spi_sclk,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  input  logic              pwr_fail,
  output logic [ADDR_W-1:0] rf_addr,
  output logic              rf_wr_en,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              rf_rd_en,
  input  logic [DATA_W-1:0] rf_rdata
);
  localparam int N_PINS   = 3;
  localparam int IDX_CS   = 2;
  localparam int IDX_SCLK = 1;
  localparam int IDX_MOSI = 0;
  localparam logic [N_PINS-1:0] PIN_RST = N_PINS'(1) << IDX_CS;

  logic [N_PINS-1:0] pins_s, pins_p;
  logic sel, sclk_rise, sclk_fall;
  logic byte_done;
  logic [DATA_W-1:0] byte_val;
  logic rx_clear, tx_clear, tx_shift;
  logic unused_prev;

  spi_rf_sync #(.N(N_PINS), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({spi_cs_n, spi_sclk, spi_mosi}),
    .sync_out (pins_s),
    .prev_out (pins_p)
  );

  assign sel         = !pins_s[IDX_CS];
  assign sclk_rise   = sel && pins_s[IDX_SCLK] && !pins_p[IDX_SCLK];
  assign sclk_fall   = sel && !pins_s[IDX_SCLK] && pins_p[IDX_SCLK];
  assign unused_prev = pins_p[IDX_CS] ^ pins_p[IDX_MOSI];

  spi_rf_rx #(.DATA_W(DATA_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (rx_clear),
    .shift_en  (sclk_rise),
    .din       (pins_s[IDX_MOSI]),
    .byte_done (byte_done),
    .byte_val  (byte_val)
  );

  spi_rf_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (sel),
    .pwr_fail  (pwr_fail),
    .sclk_fall (sclk_fall),
    .byte_done (byte_done),
    .byte_val  (byte_val),
    .rf_addr   (rf_addr),
    .rf_wr_en  (rf_wr_en),
    .rf_wdata  (rf_wdata),
    .rf_rd_en  (rf_rd_en),
    .rx_clear  (rx_clear),
    .tx_clear  (tx_clear),
    .tx_shift  (tx_shift)
  );

  spi_rf_tx #(.DATA_W(DATA_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (tx_clear),
    .load     (rf_rd_en),
    .load_val (rf_rdata),
    .shift_en (tx_shift),
    .dout     (spi_miso)
  );

  assign spi_miso_oe = sel;
endmodule

// File: rtl/spi_regfile_slave_chk.sv
module spi_regfile_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic pwr_fail,
  input logic spi_miso,
  input logic spi_miso_oe,
  input logic rf_wr_en,
  input logic rf_rd_en
);
  assert_no_dual_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rf_wr_en && rf_rd_en));

  assert_wr_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_en |=> !rf_wr_en);

  assert_rd_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rf_rd_en |=> !rf_rd_en);

  assert_pf_blocks_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> (!rf_wr_en && !rf_rd_en));

  assert_bus_in_select_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_wr_en || rf_rd_en) |-> spi_miso_oe);

  assert_miso_quiet_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_miso_oe) |-> !spi_miso);
endmodule

bind spi_regfile_slave spi_regfile_slave_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pwr_fail    (pwr_fail),
  .spi_miso    (spi_miso),
  .spi_miso_oe (spi_miso_oe),
  .rf_wr_en    (rf_wr_en),
  .rf_rd_en    (rf_rd_en)
);

// File: tb/spi_regfile_slave_bench.sv
module spi_regfile_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst_n, spi_cs_n, spi_sclk, spi_mosi, pwr_fail;
  logic spi_miso, spi_miso_oe, rf_wr_en, rf_rd_en;
  logic [5:0] rf_addr;
  logic [7:0] rf_wdata, rf_rdata;

  logic [7:0] mem [DEPTH];
  logic [7:0] exp_mem [DEPTH];
  logic [7:0] txb [0:79];
  logic [7:0] rxb [0:79];
  int wr_cnt = 0, rd_cnt = 0, n_cmp = 0, n_bad = 0;
  bit done = 0;

  spi_regfile_slave u_spi_regfile_slave (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .pwr_fail(pwr_fail), .rf_addr(rf_addr), .rf_wr_en(rf_wr_en),
    .rf_wdata(rf_wdata), .rf_rd_en(rf_rd_en), .rf_rdata(rf_rdata)
  );

  assign rf_rdata = mem[rf_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'(i) ^ 8'hA5;
    end else if (rf_wr_en) begin
      mem[rf_addr] <= rf_wdata;
    end
    if (rst_n && rf_wr_en) wr_cnt <= wr_cnt + 1;
    if (rst_n && rf_rd_en) rd_cnt <= rd_cnt + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One selection: nbytes full bytes, then tail_bits of byte nbytes.
  task automatic xfer(input bit m3, input int nbytes, input int tail_bits, input int pf_byte);
    int total;
    total = nbytes + ((tail_bits > 0) ? 1 : 0);
    spi_sclk = m3;
    waitn(HALF);
    spi_cs_n = 1'b0;
    waitn(HALF);
    for (int b = 0; b < total; b++) begin
      int nb;
      logic [7:0] rxv;
      nb = (b < nbytes) ? 8 : tail_bits;
      rxv = '0;
      for (int k = 0; k < nb; k++) begin
        if (b == pf_byte && k == 4) pwr_fail = 1'b1;
        if (pf_byte >= 0 && b == pf_byte + 1 && k == 0) pwr_fail = 1'b0;
        if (m3) spi_sclk = 1'b0;
        spi_mosi = txb[b][7-k];
        waitn(HALF);
        rxv[7-k] = spi_miso;
        spi_sclk = 1'b1;
        waitn(HALF);
        if (!m3) spi_sclk = 1'b0;
      end
      rxb[b] = rxv;
      if (b == 0) chk("R8 oe while selected", int'(spi_miso_oe), 1);
    end
    waitn(HALF);
    spi_cs_n = 1'b1;
    spi_sclk = m3;
    pwr_fail = 1'b0;
    waitn(4*HALF);
    chk("R8 miso after deselect", int'(spi_miso), 0);
    chk("R8 oe after deselect", int'(spi_miso_oe), 0);
  endtask

  task automatic do_write(input bit m3, input int start, input bit b6, input int n,
                          input int seed, input string req);
    int w0;
    txb[0] = {1'b1, b6, 6'(start)};
    for (int i = 0; i < n; i++) begin
      txb[i+1] = 8'((i * 37 + seed) & 255);
      exp_mem[(start + i) % DEPTH] = txb[i+1];
    end
    w0 = wr_cnt;
    xfer(m3, n + 1, 0, -1);
    chk({req, " write strobes"}, wr_cnt - w0, n);
  endtask

  task automatic do_read(input bit m3, input int start, input bit b6, input int n,
                         input string req);
    int w0, r0;
    txb[0] = {1'b0, b6, 6'(start)};
    for (int i = 1; i <= n; i++) txb[i] = 8'((i * 91 + 5) & 255);
    w0 = wr_cnt;
    r0 = rd_cnt;
    xfer(m3, n + 1, 0, -1);
    for (int i = 0; i < n; i++)
      chk({req, " read byte"}, int'(rxb[i+1]), int'(exp_mem[(start + i) % DEPTH]));
    chk("R3 read makes no writes", wr_cnt - w0, 0);
    chk("R10 read strobes", rd_cnt - r0, n + 1);
  endtask

  initial begin
    rst_n = 1'b0; spi_cs_n = 1'b1; spi_sclk = 1'b0; spi_mosi = 1'b0; pwr_fail = 1'b0;
    for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'(i) ^ 8'hA5;
    waitn(5);
    rst_n = 1'b1;
    waitn(2);
    chk("R1 wr_en", int'(rf_wr_en), 0);
    chk("R1 rd_en", int'(rf_rd_en), 0);
    chk("R1 miso", int'(spi_miso), 0);
    chk("R1 oe", int'(spi_miso_oe), 0);

    // R2 R3 R4: idle-low write, bit 6 set, burst wraps past 63
    do_write(1'b0, 5, 1'b1, 66, 11, "R2");
    // R5 R4 R6: idle-high read with wrap, bit 6 set
    do_read(1'b1, 60, 1'b1, 70, "R5");
    // R6: swap clock idle levels between directions
    do_write(1'b1, 33, 1'b0, 10, 77, "R6");
    do_read(1'b0, 30, 1'b0, 16, "R6");

    // R7: trailing partial data byte is dropped
    begin
      int w0;
      txb[0] = 8'h80 | 8'd20; txb[1] = 8'h3C; txb[2] = 8'hFF;
      exp_mem[20] = 8'h3C;
      w0 = wr_cnt;
      xfer(1'b0, 2, 5, -1);
      chk("R7 partial data byte strobes", wr_cnt - w0, 1);
      // R7: partial command byte, then a fresh transfer decodes normally
      txb[0] = 8'h80 | 8'd9;
      w0 = wr_cnt;
      xfer(1'b1, 0, 4, -1);
      chk("R7 partial command strobes", wr_cnt - w0, 0);
    end
    do_read(1'b0, 18, 1'b0, 5, "R7");

    // R9: power fail during data byte 3 of a 6-byte write
    begin
      int w0;
      txb[0] = 8'h80 | 8'd40;
      for (int i = 1; i <= 6; i++) txb[i] = 8'((i * 29 + 3) & 255);
      exp_mem[40] = txb[1];
      exp_mem[41] = txb[2];
      w0 = wr_cnt;
      xfer(1'b0, 7, 0, 3);
      chk("R9 writes before power fail", wr_cnt - w0, 2);
    end
    do_read(1'b1, 40, 1'b0, 8, "R9");
    // R9 recovery and R4 wrap on a short burst
    do_write(1'b0, 62, 1'b0, 4, 200, "R9");
    do_read(1'b0, 62, 1'b1, 4, "R4");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule